// File: doc/BRIEF.md
# Power Mode Sequencer for a Line-Interface Chipset

This block keeps the power state of a line-interface chipset. Software writes a control register through a simple write port. Two bits of that register choose one of four operating modes: normal, reset-hold, light sleep and deep sleep. From the chosen mode the block drives enables for the isolation link, the ring-detect output and the clock generator. It also drives a flag that tells the rest of the chip whether status from the far side of the isolation barrier can be trusted.

Three clock-generator divider registers sit beside the control register. Light sleep is accepted only when all three hold non-zero values. A light-sleep request made while any of them is zero is refused and raises a sticky error flag.

Once either sleep mode is entered, the control register is locked. The only way back is a pulse on the active-low line-reset pin. That pulse counts only while the master-clock-present flag is high. A pulse that arrives with the clock absent is dropped and raises a second sticky error flag.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `rst`, the control register (address 6) reads 0x10 and the divider registers (addresses 7, 8, 9) read 0x00, so the mode is reset-hold.
- R2: `mode` equals {ctrl[3], ctrl[4]}. The codes are 2'b00 normal, 2'b01 reset-hold, 2'b10 light sleep and 2'b11 deep sleep.
- R3: The outputs {`link_en`,`ring_en`,`clkgen_en`,`remote_ok`} take these values in each mode: normal 1111, reset-hold 0110, light sleep 1100, deep sleep 0000.
- R4: A write to address 6 with bit 3 set and bit 4 clear is refused when any of registers 7, 8 or 9 is zero. The control register keeps its value and `cfg_err` is set.
- R5: A write of 0x18 to address 6 enters deep sleep whatever the divider registers hold.
- R6: While bit 3 of the control register is set (either sleep mode), writes to address 6 have no effect.
- R7: A high-to-low change of `line_rst_n` while `clk_ok` is high restores every register to its R1 value at that clock edge, from any mode.
- R8: A high-to-low change of `line_rst_n` while `clk_ok` is low has no effect on the registers and sets `wake_err`.
- R9: If an accepted line-reset event and a register write fall on the same edge, the reset wins. If the line-reset event is refused, the write proceeds as usual.
- R10: `rd_data` returns the register at `rd_addr` for addresses 6 to 9 and zero for any other address. Writes to other addresses change nothing. All eight bits of each register are stored.
- R11: `cfg_err` and `wake_err` stay set until `rst`. A line-reset event does not clear them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| clk_ok | input | 1 | Master clock present |
| line_rst_n | input | 1 | Active-low line-reset pin |
| mode | output | 2 | Encoded operating mode |
| link_en | output | 1 | Isolation link enable |
| ring_en | output | 1 | Ring-detect output enable |
| clkgen_en | output | 1 | Clock generator enable |
| remote_ok | output | 1 | Far-side status valid |
| cfg_err | output | 1 | Sticky refused-sleep flag |
| wake_err | output | 1 | Sticky refused-wake flag |

## Verification
A line-reset event and a control-register write can land on the same clock edge. The bench provokes this twice. First, an accepted pin edge coincides with a light-sleep write while the block is running normally; the expected result is reset-hold with all registers cleared. Second, a refused pin edge (clock absent) coincides with a deep-sleep write; the expected result is deep sleep with `wake_err` set. The scoreboard models both arbitration outcomes on its own and compares mode, enables, read data and both error flags one cycle after the edge.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int NUM_DIV   = 3;
    localparam int CTRL_ADDR = 6;
    localparam int DIV_BASE  = 7;
    localparam int BIT_PDN   = 3;
    localparam int BIT_PDL   = 4;
    localparam logic [DATA_W-1:0] CTRL_INIT = 8'h10;

    typedef enum logic [1:0] {
        MD_RUN  = 2'b00,
        MD_HOLD = 2'b01,
        MD_NAP  = 2'b10,
        MD_OFF  = 2'b11
    } pmode_e;

    typedef struct packed {
        logic link_en;
        logic ring_en;
        logic clkgen_en;
        logic remote_ok;
    } pen_s;

    function automatic pmode_e decode_mode(input logic [DATA_W-1:0] c);
        return pmode_e'({c[BIT_PDN], c[BIT_PDL]});
    endfunction

    function automatic logic is_nap_req(input logic [DATA_W-1:0] c);
        return c[BIT_PDN] & ~c[BIT_PDL];
    endfunction

endpackage

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl (
    input  logic clk,
    input  logic rst,
    input  logic line_rst_n,
    input  logic clk_ok,
    output logic wake_req,
    output logic wake_err
);
    logic pin_q;
    logic pin_fall;

    assign pin_fall = pin_q & ~line_rst_n;
    assign wake_req = pin_fall & clk_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q    <= 1'b1;
            wake_err <= 1'b0;
        end else begin
            pin_q <= line_rst_n;
            if (pin_fall && !clk_ok)
                wake_err <= 1'b1;
        end
    end

    // R8
    refused_wake_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_q && !line_rst_n && !clk_ok) |=> wake_err);

    // R11
    wake_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        wake_err |=> wake_err);

endmodule

// File: rtl/pwr_regfile.sv
module pwr_regfile
    import pwr_mode_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W,
    parameter int NDIV = NUM_DIV
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wake_req,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] rd_data,
    output logic          cfg_err
);
    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);

    logic [DW-1:0] div_q [NDIV];
    logic [NDIV-1:0] div_zero;
    logic asleep, ctrl_wr, reject, any_zero;

    genvar g;
    generate
        for (g = 0; g < NDIV; g++) begin : g_zero
            assign div_zero[g] = (div_q[g] == '0);
        end
    endgenerate

    assign any_zero = |div_zero;
    assign asleep   = ctrl_q[BIT_PDN];
    assign ctrl_wr  = wr_en && (wr_addr == CTRL_A) && !asleep && !wake_req;
    assign reject   = ctrl_wr && is_nap_req(wr_data) && any_zero;

    always_ff @(posedge clk) begin
        if (rst || wake_req) begin
            ctrl_q <= CTRL_INIT;
            for (int i = 0; i < NDIV; i++) div_q[i] <= '0;
        end else begin
            if (ctrl_wr && !reject)
                ctrl_q <= wr_data;
            for (int i = 0; i < NDIV; i++)
                if (wr_en && wr_addr == AW'(DIV_BASE + i))
                    div_q[i] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_err <= 1'b0;
        else if (reject)
            cfg_err <= 1'b1;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_A)
            rd_data = ctrl_q;
        for (int i = 0; i < NDIV; i++)
            if (rd_addr == AW'(DIV_BASE + i))
                rd_data = div_q[i];
    end

    // R1
    init_value_chk: assert property (@(posedge clk)
        rst |=> (ctrl_q == CTRL_INIT));

    // R6
    sleep_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (asleep && !wake_req) |=> $stable(ctrl_q));

    // R4
    nap_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == CTRL_A && !asleep && !wake_req &&
         wr_data[BIT_PDN] && !wr_data[BIT_PDL] && any_zero)
        |=> (cfg_err && $stable(ctrl_q)));

    // R11
    cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

endmodule

// File: rtl/pwr_mode_dec.sv
module pwr_mode_dec
    import pwr_mode_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] ctrl_q,
    output pmode_e        mode,
    output pen_s          en
);
    always_comb begin
        mode = decode_mode(ctrl_q);
        unique case (mode)
            MD_RUN:  en = '{link_en: 1'b1, ring_en: 1'b1, clkgen_en: 1'b1, remote_ok: 1'b1};
            MD_HOLD: en = '{link_en: 1'b0, ring_en: 1'b1, clkgen_en: 1'b1, remote_ok: 1'b0};
            MD_NAP:  en = '{link_en: 1'b1, ring_en: 1'b1, clkgen_en: 1'b0, remote_ok: 1'b0};
            default: en = '{link_en: 1'b0, ring_en: 1'b0, clkgen_en: 1'b0, remote_ok: 1'b0};
        endcase
    end

    // R3
    always_comb begin
        remote_needs_link_chk: assert (!en.remote_ok || (en.link_en && en.clkgen_en));
    end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W,
    parameter int NDIV = NUM_DIV
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          clk_ok,
    input  logic          line_rst_n,
    output logic [1:0]    mode,
    output logic          link_en,
    output logic          ring_en,
    output logic          clkgen_en,
    output logic          remote_ok,
    output logic          cfg_err,
    output logic          wake_err
);
    logic          wake_req;
    logic [DW-1:0] ctrl_q;
    pmode_e        mode_e;
    pen_s          en;

    pwr_wake_ctl u_wake (
        .clk        (clk),
        .rst        (rst),
        .line_rst_n (line_rst_n),
        .clk_ok     (clk_ok),
        .wake_req   (wake_req),
        .wake_err   (wake_err)
    );

    pwr_regfile #(.AW(AW), .DW(DW), .NDIV(NDIV)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wake_req (wake_req),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .ctrl_q   (ctrl_q),
        .rd_data  (rd_data),
        .cfg_err  (cfg_err)
    );

    pwr_mode_dec #(.DW(DW)) u_dec (
        .ctrl_q (ctrl_q),
        .mode   (mode_e),
        .en     (en)
    );

    assign mode      = mode_e;
    assign link_en   = en.link_en;
    assign ring_en   = en.ring_en;
    assign clkgen_en = en.clkgen_en;
    assign remote_ok = en.remote_ok;

    // R7
    wake_to_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> (mode == MD_HOLD));

    // R9
    wake_beats_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_req && wr_en) |=> (ctrl_q == CTRL_INIT));

endmodule

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = 4'd6;
    logic       clk_ok = 1'b1;
    logic       line_rst_n = 1'b1;
    logic [7:0] rd_data;
    logic [1:0] mode;
    logic       link_en, ring_en, clkgen_en, remote_ok, cfg_err, wake_err;

    always #2.5 clk = ~clk;

    pwr_mode_seq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .clk_ok(clk_ok), .line_rst_n(line_rst_n),
        .mode(mode), .link_en(link_en), .ring_en(ring_en), .clkgen_en(clkgen_en),
        .remote_ok(remote_ok), .cfg_err(cfg_err), .wake_err(wake_err)
    );

    typedef struct {
        logic [1:0] mode;
        logic [3:0] en;
        logic [7:0] rd;
        logic       cerr;
        logic       werr;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;

    logic [7:0] m6 = 8'h10, m7 = 8'h00, m8 = 8'h00, m9 = 8'h00;
    logic       mcerr = 1'b0, mwerr = 1'b0, pin_prev = 1'b1;

    function automatic logic [7:0] model_rd(input logic [3:0] a);
        case (a)
            4'd6: return m6;
            4'd7: return m7;
            4'd8: return m8;
            4'd9: return m9;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [3:0] model_en(input logic [1:0] md);
        case (md)
            2'b00: return 4'b1111;
            2'b01: return 4'b0110;
            2'b10: return 4'b1100;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic push_exp(input string req);
        exp_t e;
        e.mode = {m6[3], m6[4]};
        e.en   = model_en(e.mode);
        e.rd   = model_rd(rd_addr);
        e.cerr = mcerr;
        e.werr = mwerr;
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic model_clear_regs();
        m6 = 8'h10; m7 = 8'h00; m8 = 8'h00; m9 = 8'h00;
    endtask

    // one clock of stimulus; expectation is for the state after the coming edge
    task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d,
                        input logic pin_low, input logic ok, input logic [3:0] ra,
                        input string req);
        logic fall;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        line_rst_n = ~pin_low; clk_ok = ok; rd_addr = ra;
        fall = pin_prev && pin_low;
        pin_prev = ~pin_low;
        if (fall && ok) begin
            model_clear_regs();
        end else begin
            if (fall) mwerr = 1'b1;
            if (we) begin
                case (a)
                    4'd6: if (!m6[3]) begin
                        if (d[3] && !d[4] && (m7 == 0 || m8 == 0 || m9 == 0)) mcerr = 1'b1;
                        else m6 = d;
                    end
                    4'd7: m7 = d;
                    4'd8: m8 = d;
                    4'd9: m9 = d;
                    default: ;
                endcase
            end
        end
        push_exp(req);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic [3:0] ra, input string req);
        step(1'b1, a, d, 1'b0, 1'b1, ra, req);
    endtask

    task automatic idle(input logic [3:0] ra, input string req);
        step(1'b0, 4'd0, 8'h00, 1'b0, 1'b1, ra, req);
    endtask

    task automatic do_rst(input string req);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; line_rst_n = 1'b1; clk_ok = 1'b1; rd_addr = 4'd6;
        model_clear_regs(); mcerr = 1'b0; mwerr = 1'b0; pin_prev = 1'b1;
        push_exp(req);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (mode !== e.mode || {link_en, ring_en, clkgen_en, remote_ok} !== e.en ||
                rd_data !== e.rd || cfg_err !== e.cerr || wake_err !== e.werr) begin
                n_fail++;
                $display("FAIL %s: got mode=%b en=%b rd=%h cerr=%b werr=%b, expected mode=%b en=%b rd=%h cerr=%b werr=%b",
                         e.req, mode, {link_en, ring_en, clkgen_en, remote_ok}, rd_data, cfg_err, wake_err,
                         e.mode, e.en, e.rd, e.cerr, e.werr);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_rst("R1 reset state");
        idle(4'd6, "R1 ctrl after reset");
        idle(4'd7, "R1 divider after reset");
        wr(4'd7, 8'h21, 4'd7, "R10 divider write");
        wr(4'd8, 8'h03, 4'd8, "R10 second divider");
        wr(4'd6, 8'h08, 4'd6, "R4 sleep refused with zero divider");
        wr(4'd9, 8'h40, 4'd9, "R10 third divider");
        wr(4'd6, 8'h00, 4'd6, "R2 R3 normal mode");
        wr(4'd6, 8'h05, 4'd6, "R10 low control bits stored");
        wr(4'd3, 8'hFF, 4'd3, "R10 unmapped address");
        wr(4'd6, 8'h08, 4'd6, "R3 light sleep entry");
        wr(4'd6, 8'h00, 4'd6, "R6 write ignored in sleep");
        step(1'b0, 4'd0, 8'h00, 1'b1, 1'b0, 4'd6, "R8 wake without clock refused");
        idle(4'd6, "R8 still asleep after release");
        step(1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 4'd7, "R7 wake from light sleep");
        idle(4'd6, "R7 R11 ctrl restored, flags kept");
        wr(4'd6, 8'h18, 4'd6, "R5 deep sleep with zero dividers");
        wr(4'd6, 8'h00, 4'd6, "R6 write ignored in deep sleep");
        step(1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 4'd6, "R7 wake from deep sleep");
        wr(4'd7, 8'h11, 4'd7, "R10 divider refill");
        wr(4'd8, 8'h22, 4'd8, "R10 divider refill");
        wr(4'd9, 8'h33, 4'd9, "R10 divider refill");
        wr(4'd6, 8'h00, 4'd6, "R2 normal again");
        step(1'b1, 4'd6, 8'h08, 1'b1, 1'b1, 4'd9, "R9 accepted wake beats sleep write");
        idle(4'd6, "R9 hold after collision");
        wr(4'd6, 8'h00, 4'd6, "R2 normal with zero dividers");
        step(1'b1, 4'd6, 8'h18, 1'b1, 1'b0, 4'd6, "R9 refused wake lets deep write through");
        do_rst("R11 flags cleared by rst");
        idle(4'd6, "R1 state after second reset");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule